// File: doc/BRIEF.md
# Cascadable Up/Down Byte Counter

A synchronous byte-wide counter intended to sit on a shared data bus. Every rising clock edge performs exactly one of four operations, chosen from three control inputs: an active-low parallel load strobe, a direction select, and an active-low count enable that doubles as the carry/borrow input of a chain. The operations are LOAD (copy the parallel byte), INCREMENT, DECREMENT and HOLD. Counting wraps modulo 2^WIDTH.

An active-low carry/borrow output announces that the next enabled step will roll the register over in the current direction. Feeding it into the count enable of a second instance gives a 16-bit counter, and a longer chain gives 24 bits and more. The register reaches the bus through an output stage. That stage is modelled as a data vector plus a drive-enable flag, controlled by an active-low output enable. While the output is disabled the register keeps counting.

Operation decode (the states of the step selector, with their transitions taken on each edge): OP_LOAD when the load strobe is low; otherwise OP_INC when the count enable is low and the direction is up; OP_DEC when the count enable is low and the direction is down; OP_HOLD when the count enable is high. A synchronous active-low reset forces the register to zero.

Top module: `updn_byte_counter`

## Requirements
- R1: When `rst_n` is low at a rising edge, the register becomes 0 after that edge.
- R2: When `load_n` is low, the next edge copies `din` into the register, whatever `up` and `cbi_n` are.
- R3: When `load_n` is high, `cbi_n` is low and `up` is 1, the register increments by one at the edge, and 0xFF wraps to 0x00.
- R4: When `load_n` is high, `cbi_n` is low and `up` is 0, the register decrements by one at the edge, and 0x00 wraps to 0xFF.
- R5: When `load_n` and `cbi_n` are both high, the register keeps its value, whatever `up` is.
- R6: With `up` at 1, `cbo_n` is low exactly when `cbi_n` is low and the register is all ones. Otherwise it is high.
- R7: With `up` at 0, `cbo_n` is low exactly when `cbi_n` is low and the register is all zeros. Otherwise it is high.
- R8: With `oe_n` low, `bus_drive` is 1 and `bus_q` equals the register. With `oe_n` high, `bus_drive` is 0 and `bus_q` is all zeros (high impedance).
- R9: `oe_n` has no effect on the register. Steps taken while the output is disabled are visible once it is enabled again.
- R10: Two instances chained through `cbo_n` to `cbi_n`, sharing the clock, load, direction and reset, behave as one 16-bit counter that wraps modulo 65536 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Active-low parallel load strobe |
| up | input | 1 | Direction select: 1 up, 0 down |
| cbi_n | input | 1 | Active-low carry/borrow input (count enable) |
| oe_n | input | 1 | Active-low output enable |
| din | input | WIDTH | Parallel load data |
| bus_q | output | WIDTH | Bus data, zero while not driven |
| bus_drive | output | 1 | High when the bus is actively driven |
| cbo_n | output | 1 | Active-low carry/borrow output |

## Verification
A wrong register value shows up on `bus_q` in the cycle after the faulty edge whenever the output is enabled. While the output is disabled, the error is hidden until `oe_n` falls again. A fault in the terminal-count logic shows on `cbo_n` in the same cycle, but only when the register sits at 0x00 or 0xFF. In a chained pair, the same fault corrupts the upper byte one edge later. For these reasons the stimulus steers the register across both wrap points in both directions, toggles the enable around counting, and runs a chained pair through its byte boundaries.

// File: rtl/ubc_pkg.sv
`timescale 1ns/1ps
package ubc_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_LOAD = 2'd3
    } ubc_op_e;
endpackage

// File: rtl/ubc_op_decode.sv
`timescale 1ns/1ps
module ubc_op_decode
    import ubc_pkg::*;
(
    input  logic    load_n,
    input  logic    up,
    input  logic    cbi_n,
    output ubc_op_e op
);
    always_comb begin
        unique case ({load_n, cbi_n})
            2'b00, 2'b01: op = OP_LOAD;
            2'b10:        op = up ? OP_INC : OP_DEC;
            2'b11:        op = OP_HOLD;
            default:      op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/ubc_count_core.sv
`timescale 1ns/1ps
module ubc_count_core
    import ubc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ubc_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_d;

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    always_comb begin
        unique case (op)
            OP_LOAD: count_d = din;
            OP_INC:  count_d = count_q + STEP;
            OP_DEC:  count_d = count_q - STEP;
            OP_HOLD: count_d = count_q;
            default: count_d = count_q;
        endcase
    end

    assign count = count_q;

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> count_q == '0);
    p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_INC |=> count_q == $past(count_q) + STEP);
    p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_DEC |=> count_q == $past(count_q) - STEP);
    p_hold_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_HOLD |=> $stable(count_q));
endmodule

// File: rtl/ubc_terminal.sv
`timescale 1ns/1ps
module ubc_terminal #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up,
    input  logic             cbi_n,
    output logic             cbo_n
);
    logic at_top;
    logic at_bottom;
    logic at_edge;

    always_comb begin
        at_top    = &count;
        at_bottom = ~|count;
        at_edge   = up ? at_top : at_bottom;
        cbo_n     = ~(at_edge & ~cbi_n);
    end
endmodule

// File: rtl/ubc_bus_drive.sv
`timescale 1ns/1ps
module ubc_bus_drive #(
    parameter int WIDTH = 8
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] bus_q,
    output logic             bus_drive
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign bus_q[i] = count[i] & ~oe_n;
        end
    endgenerate

    assign bus_drive = ~oe_n;
endmodule

// File: rtl/updn_byte_counter.sv
`timescale 1ns/1ps
module updn_byte_counter
    import ubc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             up,
    input  logic             cbi_n,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] bus_q,
    output logic             bus_drive,
    output logic             cbo_n
);
    ubc_op_e          op;
    logic [WIDTH-1:0] count;

    ubc_op_decode u_decode (
        .load_n (load_n),
        .up     (up),
        .cbi_n  (cbi_n),
        .op     (op)
    );

    ubc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .din    (din),
        .count  (count)
    );

    ubc_terminal #(.WIDTH(WIDTH)) u_term (
        .count  (count),
        .up     (up),
        .cbi_n  (cbi_n),
        .cbo_n  (cbo_n)
    );

    ubc_bus_drive #(.WIDTH(WIDTH)) u_bus (
        .oe_n      (oe_n),
        .count     (count),
        .bus_q     (bus_q),
        .bus_drive (bus_drive)
    );

    p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(din));
    p_carry_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !cbi_n && count == '1) |-> !cbo_n);
    p_borrow_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !cbi_n && count == '0) |-> !cbo_n);
    p_cbo_needs_cbi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cbo_n |-> !cbi_n);
    p_bus_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (bus_drive && bus_q == count));
    p_bus_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!bus_drive && bus_q == '0));
endmodule

// File: tb/updn_byte_counter_bench.sv
`timescale 1ns/1ps
module updn_byte_counter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic       up = 1'b1;
    logic       cbi_n = 1'b1;
    logic       oe_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] bus_q;
    logic       bus_drive;
    logic       cbo_n;

    logic        c_load_n = 1'b1;
    logic        c_up = 1'b1;
    logic        c_ci_n = 1'b1;
    logic [15:0] c_din = 16'h0000;
    logic [7:0]  c_lo_q, c_hi_q;
    logic        c_lo_drv, c_hi_drv, c_lo_co, c_hi_co;

    int    mdl = 0;
    int    mdl16 = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    updn_byte_counter u_updn_byte_counter (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .up(up), .cbi_n(cbi_n),
        .oe_n(oe_n), .din(din), .bus_q(bus_q), .bus_drive(bus_drive), .cbo_n(cbo_n)
    );

    updn_byte_counter u_casc_lo (
        .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .up(c_up), .cbi_n(c_ci_n),
        .oe_n(1'b0), .din(c_din[7:0]), .bus_q(c_lo_q), .bus_drive(c_lo_drv), .cbo_n(c_lo_co)
    );

    updn_byte_counter u_casc_hi (
        .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .up(c_up), .cbi_n(c_lo_co),
        .oe_n(1'b0), .din(c_din[15:8]), .bus_q(c_hi_q), .bus_drive(c_hi_drv), .cbo_n(c_hi_co)
    );

    // Behavioural reference: integers stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mdl = 0;
            mdl16 = 0;
        end else begin
            if (!load_n)     mdl = din;
            else if (!cbi_n) mdl = up ? (mdl + 1) % 256 : (mdl + 255) % 256;
            if (!c_load_n)   mdl16 = c_din;
            else if (!c_ci_n) mdl16 = c_up ? (mdl16 + 1) % 65536 : (mdl16 + 65535) % 65536;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        int exp_co;
        if (oe_n) begin
            chk("R8 bus released", int'(bus_q), 0);
            chk("R8 drive off", int'(bus_drive), 0);
        end else begin
            chk(tag, int'(bus_q), mdl);
            chk("R8 drive on", int'(bus_drive), 1);
        end
        exp_co = (!cbi_n && (up ? mdl == 255 : mdl == 0)) ? 0 : 1;
        chk(up ? "R6 cbo" : "R7 cbo", int'(cbo_n), exp_co);
        chk("R10 cascade", int'({c_hi_q, c_lo_q}), mdl16);
    endtask

    task automatic cyc(input string t, input logic ld, input logic u,
                       input logic ci, input logic oe, input logic [7:0] d);
        tag = t;
        load_n = ld; up = u; cbi_n = ci; oe_n = oe; din = d;
        @(negedge clk);
        check_all();
    endtask

    task automatic ccyc(input logic ld, input logic u, input logic ci, input logic [15:0] d);
        c_load_n = ld; c_up = u; c_ci_n = ci; c_din = d;
        tag = "R10";
        load_n = 1'b1; cbi_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check_all();
        end
        rst_n = 1'b1;
        // R1 state holds after release
        cyc("R1", 1, 1, 1, 0, 8'h00);
        // R2 load ignores direction and enable
        cyc("R2", 0, 0, 0, 0, 8'h5A);
        cyc("R2", 0, 1, 1, 0, 8'hC3);
        cyc("R2", 0, 1, 0, 0, 8'hFB);
        // R3 count up across the wrap
        for (int i = 0; i < 8; i++) cyc("R3", 1, 1, 0, 0, 8'h00);
        // R4 count down across the wrap
        cyc("R2", 0, 0, 0, 0, 8'h03);
        for (int i = 0; i < 6; i++) cyc("R4", 1, 0, 0, 0, 8'h00);
        // R5 hold with direction toggling
        for (int i = 0; i < 4; i++) cyc("R5", 1, i[0], 1, 0, 8'hAA);
        // R6 terminal detect at all ones, qualified by enable
        cyc("R2", 0, 1, 1, 0, 8'hFF);
        cyc("R6", 1, 1, 1, 0, 8'h00);
        cyc("R6", 1, 0, 1, 0, 8'h00);
        tag = "R6"; up = 1'b1; cbi_n = 1'b0; #1; check_all();
        up = 1'b0; #1; check_all();
        // R7 terminal detect at all zeros
        cyc("R2", 0, 0, 1, 0, 8'h00);
        cyc("R7", 1, 0, 1, 0, 8'h00);
        tag = "R7"; cbi_n = 1'b0; #1; check_all();
        up = 1'b1; #1; check_all();
        // R8/R9 count while released, then reveal
        cyc("R2", 0, 1, 1, 0, 8'h10);
        for (int i = 0; i < 5; i++) cyc("R9", 1, 1, 0, 1, 8'h00);
        cyc("R9", 1, 1, 1, 0, 8'h00);
        chk("R9 value after reveal", int'(bus_q), 8'h15);
        cyc("R9", 0, 0, 0, 1, 8'h77);
        cyc("R9", 1, 0, 1, 0, 8'h00);
        // R1 reset in mid-run
        rst_n = 1'b0;
        cyc("R1", 1, 1, 0, 0, 8'h00);
        chk("R1 mid-run reset", int'(bus_q), 0);
        rst_n = 1'b1;
        // R10 chained pair across byte boundaries
        ccyc(0, 1, 0, 16'h00FD);
        for (int i = 0; i < 5; i++) ccyc(1, 1, 0, 16'h0000);
        ccyc(0, 0, 0, 16'h0102);
        for (int i = 0; i < 5; i++) ccyc(1, 0, 0, 16'h0000);
        ccyc(0, 1, 1, 16'hFFFE);
        for (int i = 0; i < 3; i++) ccyc(1, 1, 0, 16'h0000);
        for (int i = 0; i < 3; i++) ccyc(1, 0, 0, 16'h0000);
        ccyc(1, 0, 1, 16'h0000);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule